// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits in a CAN receive path, after the bit-level receiver and before any frame storage. For each received frame it looks at a descriptor: the identifier, the extended and remote flags, the data length code and the first two data bytes. It decides whether the frame is kept or dropped. The decision is set by eight configuration bytes, four code bytes and four mask bytes. Each mask byte has the same bit layout as the code byte it pairs with. A mask bit of 1 makes the matching bit a don't-care. Every compared bit must satisfy `(received & ~mask) == (code & ~mask)`.

Two filter shapes are offered. In single mode the full code/mask set forms one wide filter. For an extended frame it covers the whole 29-bit identifier and the remote flag. For a standard frame it covers the identifier, the remote flag and up to two data bytes. In dual mode the same eight bytes are split into two narrower filters, and a frame is kept when either one matches. A bypass input makes the block accept every frame.

The frame descriptor and the configuration are sampled on the clock edge that sees the `frm_valid` strobe. One clock later the block raises `dec_valid` together with exactly one of `dec_accept` and `dec_reject`.

Top module: `can_accept_filter`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid`, `dec_accept` and `dec_reject` are all 0.
- R2: A `frm_valid` strobe at clock edge N raises `dec_valid` for one cycle after edge N, together with exactly one of `dec_accept` and `dec_reject`. With no strobe all three stay 0. Back-to-back strobes each give their own decision.
- R3: When `cfg_bypass` is 1, every frame is accepted, whatever the mode, the code and the mask.
- R4: Code byte k is `cfg_code[8k+7:8k]` and mask byte k is `cfg_mask[8k+7:8k]`, for k = 0 to 3. The two use the same bit layout. A mask bit of 1 removes the corresponding bit from the comparison.
- R5: In single mode (`cfg_dual`=0), an extended frame (`frm_ext`=1) matches when all of the following hold: byte0 holds ID28..21, byte1 holds ID20..13, byte2 holds ID12..5, byte3 bits 7..3 hold ID4..0, and byte3 bit 2 holds the remote flag. Byte3 bits 1..0 are not compared.
- R6: In single mode, a standard frame (`frm_ext`=0) compares its 11-bit identifier `frm_id[10:0]` with byte0 (ID10..3) and byte1 bits 7..5 (ID2..0). It compares the remote flag with byte1 bit 4. `frm_id[28:11]` is ignored.
- R7: In single mode, a standard frame whose identifier and remote flag match is accepted at once if it is a remote frame or its DLC is 0. Otherwise data byte 0 must match byte2. Data byte 1 must also match byte3, but only when DLC is 2 or more.
- R8: In dual mode, an extended frame is compared only on ID28..13. Filter A uses bytes 0 (ID28..21) and 1 (ID20..13). Filter B uses bytes 2 and 3 in the same way. ID12..0 and the remote flag are ignored. The frame is accepted if A or B matches.
- R9: In dual mode, filter A for a standard frame compares the identifier and remote flag against byte0 and byte1 bits 7..4, using the R6 layout. It also compares data byte 0, regardless of DLC and remote flag, against `{byte1[3:0], byte3[3:0]}`, with the mask formed the same way.
- R10: In dual mode, filter B for a standard frame compares only the identifier and remote flag, against byte2 and byte3 bits 7..4 in the R6 layout. The frame is accepted if A or B matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | Frame descriptor strobe, one cycle per frame |
| frm_id | input | 29 | Identifier; standard frames use bits 10..0 |
| frm_ext | input | 1 | 1 = extended (29-bit) frame |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| cfg_code | input | 32 | Four code bytes, byte k at bits 8k+7..8k |
| cfg_mask | input | 32 | Four mask bytes, same layout, 1 = don't care |
| cfg_dual | input | 1 | 1 = dual-filter mode, 0 = single-filter mode |
| cfg_bypass | input | 1 | 1 = accept every frame |
| dec_valid | output | 1 | Decision present, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame rejected |

## Verification
The bench targets the DLC gating of single-mode standard frames. A design that always checks data byte 1 rejects one-byte frames with a stray second byte. A design that skips the remote or zero-length shortcut rejects frames that should pass. Dual-mode standard frames are probed with a wrong data byte and DLC 0, which a design that gates the nibble comparison on length would wrongly accept. The bench also checks that filter B never looks at data at all. Single bits are flipped and then masked to catch a shifted byte layout, and the unused high identifier bits of standard frames are filled with noise. Several hundred random frames are run back to back across mixed modes, against a bench model.

// File: rtl/acf_pkg.sv
// acf_pkg: shared widths, the frame descriptor type and a byte helper
// for the CAN acceptance filter. Assumes byte k of a configuration word
// sits at bits 8k+7..8k.
package acf_pkg;
    localparam int BYTE_W     = 8;
    localparam int CFG_BYTES  = 4;
    localparam int CFG_W      = CFG_BYTES * BYTE_W;
    localparam int EXT_ID_W   = 29;
    localparam int STD_ID_W   = 11;
    localparam int DLC_W      = 4;
    localparam int DUAL_ID_W  = 2 * BYTE_W;
    localparam int DUAL_SLOTS = 2;
    localparam int NIB_W      = BYTE_W / 2;

    typedef struct packed {
        logic [EXT_ID_W-1:0] id;
        logic                ext;
        logic                rtr;
        logic [DLC_W-1:0]    dlc;
        logic [BYTE_W-1:0]   d0;
        logic [BYTE_W-1:0]   d1;
    } acf_frame_t;

    // Pick byte k out of a configuration word.
    function automatic logic [BYTE_W-1:0] cfg_byte(input logic [CFG_W-1:0] word, input int k);
        return word[k*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/acf_masked_eq.sv
// acf_masked_eq: masked equality of a received field against a code field.
// A mask bit of 1 excludes that bit. Purely combinational.
module acf_masked_eq #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_bits,
    input  logic [W-1:0] code_bits,
    input  logic [W-1:0] mask_bits,
    output logic         hit
);
    // Compare only the bits the mask keeps.
    always_comb begin
        hit = ((rx_bits ^ code_bits) & ~mask_bits) == '0;
    end
endmodule

// File: rtl/acf_single_filter.sv
// acf_single_filter: one wide filter built from all four code/mask bytes.
// Extended frames: 29-bit ID plus remote flag. Standard frames: 11-bit ID,
// remote flag, then data bytes gated by remote flag and DLC.
// Assumes the frame fields are stable while the result is used.
module acf_single_filter
    import acf_pkg::*;
(
    input  acf_frame_t       frm,
    input  logic [CFG_W-1:0] code,
    input  logic [CFG_W-1:0] mask,
    output logic             hit
);
    localparam int EXT_CMP_W = EXT_ID_W + 1;
    localparam int STD_CMP_W = STD_ID_W + 1;
    localparam int EXT_TAIL  = EXT_CMP_W - 3 * BYTE_W;
    localparam int STD_TAIL  = STD_CMP_W - BYTE_W;

    logic [BYTE_W-1:0] c0, c1, c2, c3, m0, m1, m2, m3;
    logic ext_hit, std_id_hit, d0_hit, d1_hit, std_hit;
    logic data_exempt, need_d1;

    assign c0 = cfg_byte(code, 0);
    assign c1 = cfg_byte(code, 1);
    assign c2 = cfg_byte(code, 2);
    assign c3 = cfg_byte(code, 3);
    assign m0 = cfg_byte(mask, 0);
    assign m1 = cfg_byte(mask, 1);
    assign m2 = cfg_byte(mask, 2);
    assign m3 = cfg_byte(mask, 3);

    acf_masked_eq #(.W(EXT_CMP_W)) u_ext (
        .rx_bits   ({frm.id, frm.rtr}),
        .code_bits ({c0, c1, c2, c3[BYTE_W-1 -: EXT_TAIL]}),
        .mask_bits ({m0, m1, m2, m3[BYTE_W-1 -: EXT_TAIL]}),
        .hit       (ext_hit)
    );

    acf_masked_eq #(.W(STD_CMP_W)) u_std (
        .rx_bits   ({frm.id[STD_ID_W-1:0], frm.rtr}),
        .code_bits ({c0, c1[BYTE_W-1 -: STD_TAIL]}),
        .mask_bits ({m0, m1[BYTE_W-1 -: STD_TAIL]}),
        .hit       (std_id_hit)
    );

    acf_masked_eq #(.W(BYTE_W)) u_d0 (
        .rx_bits   (frm.d0),
        .code_bits (c2),
        .mask_bits (m2),
        .hit       (d0_hit)
    );

    acf_masked_eq #(.W(BYTE_W)) u_d1 (
        .rx_bits   (frm.d1),
        .code_bits (c3),
        .mask_bits (m3),
        .hit       (d1_hit)
    );

    // Decide which data bytes a standard frame must match.
    always_comb begin
        data_exempt = frm.rtr || (frm.dlc == '0);
        need_d1     = frm.dlc >= DLC_W'(2);
        std_hit     = std_id_hit && (data_exempt || (d0_hit && (!need_d1 || d1_hit)));
    end

    // Pick the result for the frame format.
    always_comb begin
        hit = frm.ext ? ext_hit : std_hit;
    end
endmodule

// File: rtl/acf_dual_filter.sv
// acf_dual_filter: two narrow filters sharing the four code/mask bytes.
// Slot g uses bytes 2g and 2g+1. Extended frames compare ID28..13 only.
// Standard frames compare ID and remote flag. Slot 0 also checks data
// byte 0 against the low nibbles of bytes 1 and 3. A hit in either slot wins.
module acf_dual_filter
    import acf_pkg::*;
(
    input  acf_frame_t       frm,
    input  logic [CFG_W-1:0] code,
    input  logic [CFG_W-1:0] mask,
    output logic             hit
);
    localparam int STD_CMP_W = STD_ID_W + 1;
    localparam int STD_TAIL  = STD_CMP_W - BYTE_W;

    logic [DUAL_SLOTS-1:0] ext_hit, std_id_hit, data_hit, std_hit;
    logic unused_fields;

    // Fields no dual-mode comparison reads.
    assign unused_fields = ^{frm.id[EXT_ID_W-DUAL_ID_W-1:STD_ID_W], frm.dlc, frm.d1};

    for (genvar g = 0; g < DUAL_SLOTS; g++) begin : g_slot
        logic [BYTE_W-1:0] c_hi, c_lo, m_hi, m_lo;
        assign c_hi = cfg_byte(code, 2 * g);
        assign c_lo = cfg_byte(code, 2 * g + 1);
        assign m_hi = cfg_byte(mask, 2 * g);
        assign m_lo = cfg_byte(mask, 2 * g + 1);

        acf_masked_eq #(.W(DUAL_ID_W)) u_ext (
            .rx_bits   (frm.id[EXT_ID_W-1 -: DUAL_ID_W]),
            .code_bits ({c_hi, c_lo}),
            .mask_bits ({m_hi, m_lo}),
            .hit       (ext_hit[g])
        );

        acf_masked_eq #(.W(STD_CMP_W)) u_std (
            .rx_bits   ({frm.id[STD_ID_W-1:0], frm.rtr}),
            .code_bits ({c_hi, c_lo[BYTE_W-1 -: STD_TAIL]}),
            .mask_bits ({m_hi, m_lo[BYTE_W-1 -: STD_TAIL]}),
            .hit       (std_id_hit[g])
        );

        if (g == 0) begin : g_data
            logic [BYTE_W-1:0] c1, c3, m1, m3;
            assign c1 = cfg_byte(code, 1);
            assign c3 = cfg_byte(code, 3);
            assign m1 = cfg_byte(mask, 1);
            assign m3 = cfg_byte(mask, 3);
            acf_masked_eq #(.W(BYTE_W)) u_d0 (
                .rx_bits   (frm.d0),
                .code_bits ({c1[NIB_W-1:0], c3[NIB_W-1:0]}),
                .mask_bits ({m1[NIB_W-1:0], m3[NIB_W-1:0]}),
                .hit       (data_hit[g])
            );
        end else begin : g_nodata
            assign data_hit[g] = 1'b1;
        end

        assign std_hit[g] = std_id_hit[g] & data_hit[g];
    end

    // Either slot accepting is enough.
    always_comb begin
        hit = frm.ext ? (|ext_hit) : (|std_hit);
    end
endmodule

// File: rtl/can_accept_filter.sv
// can_accept_filter: top of the CAN acceptance filter. Picks the single,
// dual or bypass result and registers a one-cycle decision after each
// frm_valid strobe. Assumes the descriptor and configuration are valid on
// the strobe edge. Synchronous active-low reset.
module can_accept_filter
    import acf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [EXT_ID_W-1:0] frm_id,
    input  logic                frm_ext,
    input  logic                frm_rtr,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [BYTE_W-1:0]   frm_data0,
    input  logic [BYTE_W-1:0]   frm_data1,
    input  logic [CFG_W-1:0]    cfg_code,
    input  logic [CFG_W-1:0]    cfg_mask,
    input  logic                cfg_dual,
    input  logic                cfg_bypass,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic                dec_reject
);
    acf_frame_t frm;
    logic hit_single, hit_dual, hit_sel;

    // Gather the descriptor into one bundle.
    always_comb begin
        frm = '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc,
                d0: frm_data0, d1: frm_data1};
    end

    acf_single_filter u_single (
        .frm  (frm),
        .code (cfg_code),
        .mask (cfg_mask),
        .hit  (hit_single)
    );

    acf_dual_filter u_dual (
        .frm  (frm),
        .code (cfg_code),
        .mask (cfg_mask),
        .hit  (hit_dual)
    );

    // Select the result for the configured mode.
    always_comb begin
        if (cfg_bypass) hit_sel = 1'b1;
        else if (cfg_dual) hit_sel = hit_dual;
        else hit_sel = hit_single;
    end

    // Register the decision pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reject <= 1'b0;
        end else begin
            dec_valid  <= frm_valid;
            dec_accept <= frm_valid & hit_sel;
            dec_reject <= frm_valid & ~hit_sel;
        end
    end
endmodule

// File: rtl/acf_checker.sv
// acf_checker: timing and mode properties of can_accept_filter, bound to
// every instance of the top module.
module acf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_valid,
    input logic [28:0] frm_id,
    input logic        frm_ext,
    input logic        frm_rtr,
    input logic [3:0]  frm_dlc,
    input logic [31:0] cfg_code,
    input logic [31:0] cfg_mask,
    input logic        cfg_dual,
    input logic        cfg_bypass,
    input logic        dec_valid,
    input logic        dec_accept,
    input logic        dec_reject
);
    // R2
    one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $countones({dec_accept, dec_reject}) == 1);

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid && !dec_accept && !dec_reject);

    // R3
    bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && cfg_bypass) |=> dec_accept);

    // R4
    full_mask_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_bypass && !cfg_dual && frm_ext && (&cfg_mask)) |=> dec_accept);

    // R7
    std_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_bypass && !cfg_dual && !frm_ext && (&cfg_mask[15:0])
         && (frm_rtr || frm_dlc == 4'd0)) |=> dec_accept);

    // R8
    dual_ext_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_bypass && cfg_dual && frm_ext && cfg_mask[15:0] == 16'h0
         && {cfg_code[7:0], cfg_code[15:8]} == frm_id[28:13]) |=> dec_accept);
endmodule

bind can_accept_filter acf_checker u_acf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_id     (frm_id),
    .frm_ext    (frm_ext),
    .frm_rtr    (frm_rtr),
    .frm_dlc    (frm_dlc),
    .cfg_code   (cfg_code),
    .cfg_mask   (cfg_mask),
    .cfg_dual   (cfg_dual),
    .cfg_bypass (cfg_bypass),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_reject (dec_reject)
);

// File: tb/sim_can_accept_filter.sv
// Scoreboard bench: send() computes the expected decision and queues it;
// the monitor pops one entry per dec_valid and compares.
module sim_can_accept_filter;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [3:0]  frm_dlc = '0;
    logic [7:0]  frm_data0 = '0, frm_data1 = '0;
    logic [31:0] cfg_code = '0, cfg_mask = '0;
    logic        cfg_dual = 1'b0, cfg_bypass = 1'b0;
    logic        dec_valid, dec_accept, dec_reject;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit exp_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    can_accept_filter u0 (.*);

    function automatic bit meq(input logic [31:0] a, input logic [31:0] c, input logic [31:0] m);
        return ((a ^ c) & ~m) == 32'h0;
    endfunction

    // Expected decision, written from the requirements.
    function automatic bit model(input logic [28:0] id, input bit ext, input bit rtr,
                                 input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] c [4];
        logic [7:0] m [4];
        bit a, b;
        for (int k = 0; k < 4; k++) begin
            c[k] = cfg_code[8*k +: 8];
            m[k] = cfg_mask[8*k +: 8];
        end
        if (cfg_bypass) return 1'b1;                                  // R3
        if (!cfg_dual) begin
            if (ext)                                                  // R5
                return meq({3'b0, id[28:21], id[20:13], id[12:5], id[4:0], rtr},
                           {3'b0, c[0], c[1], c[2], c[3][7:2]},
                           {3'b0, m[0], m[1], m[2], m[3][7:2]});
            if (!meq({20'h0, id[10:0], rtr}, {20'h0, c[0], c[1][7:4]},
                     {20'h0, m[0], m[1][7:4]})) return 1'b0;          // R6
            if (rtr || dlc == 0) return 1'b1;                         // R7
            if (!meq({24'h0, d0}, {24'h0, c[2]}, {24'h0, m[2]})) return 1'b0;
            if (dlc < 2) return 1'b1;
            return meq({24'h0, d1}, {24'h0, c[3]}, {24'h0, m[3]});
        end
        if (ext) begin                                                // R8
            a = meq({16'h0, id[28:13]}, {16'h0, c[0], c[1]}, {16'h0, m[0], m[1]});
            b = meq({16'h0, id[28:13]}, {16'h0, c[2], c[3]}, {16'h0, m[2], m[3]});
            return a | b;
        end
        a = meq({20'h0, id[10:0], rtr}, {20'h0, c[0], c[1][7:4]}, {20'h0, m[0], m[1][7:4]})
            && meq({24'h0, d0}, {24'h0, c[1][3:0], c[3][3:0]},
                   {24'h0, m[1][3:0], m[3][3:0]});                    // R9
        b = meq({20'h0, id[10:0], rtr}, {20'h0, c[2], c[3][7:4]}, {20'h0, m[2], m[3][7:4]}); // R10
        return a | b;
    endfunction

    task automatic set_cfg(input logic [31:0] code, input logic [31:0] mask, input bit dual, input bit byp);
        cfg_code = code; cfg_mask = mask; cfg_dual = dual; cfg_bypass = byp;
    endtask

    // Driver: called at a falling edge, holds the strobe for one cycle.
    task automatic send(input string tag, input logic [28:0] id, input bit ext, input bit rtr,
                        input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1);
        exp_q.push_back(model(id, ext, rtr, dlc, d0, d1));
        tag_q.push_back(tag);
        frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
        frm_data0 = d0; frm_data1 = d1; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    // Monitor: sample a quarter period after the rising edge.
    always @(posedge clk) begin
        #(CLK_PER/4);
        if (rst_n && !finished && dec_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected decision: actual valid=1 expected valid=0");
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (dec_accept !== e || dec_reject !== !e) begin
                    n_bad++;
                    $display("FAIL %s: actual accept=%0b reject=%0b expected accept=%0b reject=%0b",
                             t, dec_accept, dec_reject, e, !e);
                end
            end
        end
    end

    function automatic logic [31:0] pack_sx(input logic [28:0] id, input bit rtr);
        return {id[4:0], rtr, 2'b00, id[12:5], id[20:13], id[28:21]};
    endfunction

    function automatic logic [31:0] pack_ss(input logic [10:0] id, input bit rtr,
                                            input logic [7:0] d0, input logic [7:0] d1);
        return {d1, d0, id[2:0], rtr, 4'h0, id[10:3]};
    endfunction

    initial begin
        logic [28:0] ida, idb;
        logic [10:0] sa, sb;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({dec_valid, dec_accept, dec_reject} !== 3'b000) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%b expected=000", {dec_valid, dec_accept, dec_reject});
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 single extended
        ida = 29'h1ABCDE5;
        set_cfg(pack_sx(ida, 1'b0), 32'h0, 1'b0, 1'b0);
        send("R5 ext exact", ida, 1, 0, 4'd8, 8'h11, 8'h22);
        send("R5 ext id0 flipped", ida ^ 29'h1, 1, 0, 4'd8, 8'h11, 8'h22);
        send("R5 ext rtr mismatch", ida, 1, 1, 4'd0, 8'h00, 8'h00);
        send("R5 ext id28 flipped", ida ^ 29'h1000_0000, 1, 0, 4'd1, 8'h00, 8'h00);
        set_cfg(pack_sx(ida, 1'b0), 32'h0800_0000, 1'b0, 1'b0);
        send("R4 ext id0 masked", ida ^ 29'h1, 1, 0, 4'd8, 8'h11, 8'h22);
        set_cfg(pack_sx(ida, 1'b0), 32'hFFFF_FFFF, 1'b0, 1'b0);
        send("R4 ext all masked", 29'h0F0F0F0, 1, 1, 4'd3, 8'h00, 8'h00);

        // R6 / R7 single standard
        sa = 11'h5A3;
        set_cfg(pack_ss(sa, 1'b0, 8'h81, 8'h3C), 32'h0, 1'b0, 1'b0);
        send("R6 std exact dlc2", {18'h0, sa}, 0, 0, 4'd2, 8'h81, 8'h3C);
        send("R6 std high id bits ignored", {18'h3FFFF, sa}, 0, 0, 4'd2, 8'h81, 8'h3C);
        send("R6 std id bit flipped", {18'h0, sa ^ 11'h040}, 0, 0, 4'd2, 8'h81, 8'h3C);
        send("R6 std rtr mismatch", {18'h0, sa}, 0, 1, 4'd0, 8'h81, 8'h3C);
        send("R7 std dlc0 data ignored", {18'h0, sa}, 0, 0, 4'd0, 8'h00, 8'h00);
        send("R7 std dlc1 d0 wrong", {18'h0, sa}, 0, 0, 4'd1, 8'h80, 8'h3C);
        send("R7 std dlc1 d1 ignored", {18'h0, sa}, 0, 0, 4'd1, 8'h81, 8'hC3);
        send("R7 std dlc2 d1 wrong", {18'h0, sa}, 0, 0, 4'd2, 8'h81, 8'hC3);
        send("R7 std dlc8 d1 wrong", {18'h0, sa}, 0, 0, 4'd8, 8'h81, 8'h3D);
        set_cfg(pack_ss(sa, 1'b0, 8'h81, 8'h3C), 32'h0000_1000, 1'b0, 1'b0);
        send("R7 std rtr skips data", {18'h0, sa}, 0, 1, 4'd8, 8'h00, 8'h00);
        send("R7 std data frame checks data", {18'h0, sa}, 0, 0, 4'd8, 8'h00, 8'h00);
        set_cfg(pack_ss(sa, 1'b0, 8'h81, 8'h3C), 32'hFF00_0000, 1'b0, 1'b0);
        send("R4 std d1 masked", {18'h0, sa}, 0, 0, 4'd2, 8'h81, 8'hC3);

        // R8 dual extended
        ida = 29'h12345678 & 29'h1FFFFFFF;
        idb = 29'h0BEEF123;
        set_cfg({idb[20:13], idb[28:21], ida[20:13], ida[28:21]}, 32'h0, 1'b1, 1'b0);
        send("R8 dual ext A, low bits differ", ida ^ 29'h1FFF, 1, 1, 4'd0, 8'h00, 8'h00);
        send("R8 dual ext B", idb, 1, 0, 4'd4, 8'h55, 8'h66);
        send("R8 dual ext none", ida ^ 29'h2000, 1, 0, 4'd4, 8'h55, 8'h66);

        // R9 / R10 dual standard
        sa = 11'h2C7; sb = 11'h613;
        set_cfg({sb[2:0], 1'b0, 4'h5, sb[10:3], sa[2:0], 1'b0, 4'hC, sa[10:3]}, 32'h0, 1'b1, 1'b0);
        send("R9 dual std A data match", {18'h0, sa}, 0, 0, 4'd1, 8'hC5, 8'h00);
        send("R9 dual std A data wrong", {18'h0, sa}, 0, 0, 4'd1, 8'hC4, 8'h00);
        send("R9 dual std A data checked at dlc0", {18'h0, sa}, 0, 0, 4'd0, 8'hC4, 8'h00);
        send("R10 dual std B any data", {18'h0, sb}, 0, 0, 4'd8, 8'h00, 8'hFF);
        send("R10 dual std B rtr mismatch", {18'h0, sb}, 0, 1, 4'd0, 8'h00, 8'h00);
        send("R10 dual std none", {18'h0, sb ^ 11'h001}, 0, 0, 4'd1, 8'hC5, 8'h00);
        set_cfg({sb[2:0], 1'b0, 4'h5, sb[10:3], sa[2:0], 1'b0, 4'hC, sa[10:3]}, 32'h0F00_0000, 1'b1, 1'b0);
        send("R9 dual std A low nibble masked", {18'h0, sa}, 0, 0, 4'd1, 8'hC4, 8'h00);

        // R3 bypass
        set_cfg(32'hDEAD_BEEF, 32'h0, 1'b0, 1'b1);
        send("R3 bypass single std", 29'h7, 0, 0, 4'd2, 8'h01, 8'h02);
        set_cfg(32'hDEAD_BEEF, 32'h0, 1'b1, 1'b1);
        send("R3 bypass dual ext", 29'h1, 1, 1, 4'd0, 8'h00, 8'h00);

        // R2 idle gap: no strobe, no decision (monitor flags any stray pulse)
        repeat (4) @(negedge clk);
        n_chk++;
        if (dec_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle: actual valid=%b expected valid=0", dec_valid);
        end

        // R2 / R4..R10 back-to-back random frames in mixed modes
        for (int i = 0; i < 400; i++) begin
            logic [28:0] rid;
            bit rext;
            if (i % 8 == 0)
                set_cfg($urandom, $urandom | $urandom, 1'($urandom), 1'(($urandom % 10) == 0));
            rext = 1'($urandom);
            rid = 29'($urandom);
            if (($urandom % 3) == 0) begin
                if (rext) rid = {cfg_code[7:0], cfg_code[15:8], cfg_code[23:16], cfg_code[31:27]};
                else rid[10:0] = {cfg_code[7:0], cfg_code[15:13]};
            end
            send("R2 random stream", rid, rext, 1'($urandom), 4'($urandom),
                 8'($urandom), 8'($urandom));
        end
        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing decisions: actual left=%0d expected left=0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule